// File: doc/BRIEF.md
# Hybrid Counter and Phase-Tap Pulse Width Modulator

This block produces one pulse width modulated output whose duty resolution is four times finer than its counter clock. A 7-bit free-running counter, stepped by the 0° clock, sets the switching period to 128 clock cycles. It also compares against the upper seven bits of a 9-bit duty word to form a coarse pulse. Three single-flop taps re-time that coarse pulse on externally supplied copies of the clock that lag by 90°, 180° and 270°. This gives four candidate pulses, each one a quarter clock later than the one before. The two low duty bits pick the candidate that ends the output pulse. The coarse pulse always starts it.

A duty word is presented with a one-cycle load strobe. It is held pending and becomes active only at the counter wrap. A period already under way therefore always completes with the word it started with. The phase clocks are produced outside this block, and so is any delay matching.

Top module: `hybrid_phase_pwm`

## Requirements
- R1: The counter advances on every rising 0° edge and wraps from 127 to 0, so output pulses start exactly 128 clock periods apart.
- R2: With duty bits [1:0] = 00 and bits [8:2] = C (C ≥ 1), the output rises at the wrap edge and stays high for exactly C clock periods.
- R3: Duty bits [1:0] = F lengthen the pulse by F quarter clock periods: 01 ends it on the 90° tap, 10 on the 180° tap and 11 on the 270° tap. The high time is C clock periods plus F quarters.
- R4: When bits [8:2] are zero, the output stays constantly low whatever bits [1:0] hold. This covers duty word 0.
- R5: Duty word 511 gives a high time of 127¾ clock periods, which leaves the output low for one quarter clock before each wrap.
- R6: A word loaded while the counter is not at 127 does not change the period in progress. It takes effect from the next wrap.
- R7: A load strobe sampled on the same edge as the wrap (counter at 127) applies its word to the period that begins at that edge.
- R8: When several words are loaded within one period, the last one loaded before the wrap is the one applied.
- R9: Pulling rst_n low forces the output low at once and clears the counter, the active and pending duty words and all taps. After release the output stays low until a nonzero word is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_p0 | input | 1 | Reference clock, 0° phase; steps the counter and duty registers |
| clk_p90 | input | 1 | Clock copy lagging by a quarter period |
| clk_p180 | input | 1 | Clock copy lagging by half a period |
| clk_p270 | input | 1 | Clock copy lagging by three quarters of a period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| duty_in | input | 9 | Duty word: bits [8:2] whole clocks, bits [1:0] quarter clocks |
| duty_load | input | 1 | Captures duty_in on the next rising 0° edge |
| pwm_out | output | 1 | Modulated output |

## Verification
A duty load and the counter wrap can land on the same 0° edge. There, the rule is that the word being loaded bypasses the pending register and governs the new period at once. The bench locks onto a rising output edge and counts 127 reference edges. It then holds the strobe high across the following wrap edge with a short word. The next pulse must start exactly 512 ns after the previous one and must have the short word's width, not the old word's width. A second scenario loads a word mid-pulse and checks that the current pulse still ends at its old time.

// File: rtl/hpwm_pkg.sv
`timescale 1ns/1ps
package hpwm_pkg;
  // Total duty word width and the part resolved by clock phases.
  localparam int DUTY_W      = 9;
  localparam int FINE_W      = 2;
  localparam int COARSE_W    = DUTY_W - FINE_W;
  localparam int NPHASE      = 1 << FINE_W;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hpwm_rst_sync.sv
`timescale 1ns/1ps
// Reset bridge: asserts asynchronously, releases on the local clock.
module hpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/hpwm_coarse.sv
`timescale 1ns/1ps
// Counter, pending/active duty registers and coarse comparator.
module hpwm_coarse #(
  parameter int DUTY_W = hpwm_pkg::DUTY_W,
  parameter int FINE_W = hpwm_pkg::FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              load_i,
  output logic              pulse_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              wrap_o,
  output logic              idle_o
);
  localparam int CW = DUTY_W - FINE_W;
  localparam logic [CW-1:0] CNT_LAST = '1;

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DUTY_W-1:0] pend_q, pend_d;
  logic [DUTY_W-1:0] act_q, act_d, act_next;
  logic              pulse_q, pulse_d;
  logic              pend_en, act_en;

  // Next-state logic
  always_comb begin
    cnt_d    = cnt_q + CW'(1);
    wrap_o   = (cnt_q == CNT_LAST);
    pend_en  = load_i;
    pend_d   = duty_i;
    act_en   = wrap_o;
    // a strobe on the wrap edge bypasses the pending register
    act_d    = load_i ? duty_i : pend_q;
    act_next = act_en ? act_d : act_q;
    // registered compare, aligned with the 0 degree edge
    pulse_d  = (cnt_d < act_next[DUTY_W-1:FINE_W]);
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign pulse_o = pulse_q;
  assign fine_o  = act_q[FINE_W-1:0];
  assign idle_o  = (act_q[DUTY_W-1:FINE_W] == '0);

  // Counter steps by one between wraps (R1)
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> cnt_q == $past(cnt_q) + CW'(1));
  // Counter returns to zero after its last value (R1)
  p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
  // Active word only moves at the wrap (R6)
  p_defer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(act_q));
  // Load on the wrap edge takes effect at once (R7)
  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && load_i) |=> act_q == $past(duty_i));
  // Latest load overwrites the pending word (R8)
  p_last_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_q == $past(duty_i));
endmodule

// File: rtl/hpwm_phase_tap.sv
`timescale 1ns/1ps
// One re-timing flop clocked by a shifted clock phase.
module hpwm_phase_tap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic tap_q, tap_d;

  always_comb begin
    tap_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_d;
  end

  assign q_o = tap_q;
endmodule

// File: rtl/hpwm_merge.sv
`timescale 1ns/1ps
// Tap selection and set-dominant merge with an active-low release.
module hpwm_merge #(
  parameter int SEL_W = hpwm_pkg::FINE_W,
  parameter int NSEL  = 1 << SEL_W
) (
  input  logic             set_i,
  input  logic [NSEL-1:0]  tap_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pwm_o
);
  logic release_n;

  always_comb begin
    release_n = tap_i[sel_i];
    // Set wins. Otherwise a low tap releases the output. A high tap can
    // only follow a set in the same period, so holding equals the tap level.
    if (set_i)           pwm_o = 1'b1;
    else if (!release_n) pwm_o = 1'b0;
    else                 pwm_o = 1'b1;
  end
endmodule

// File: rtl/hybrid_phase_pwm.sv
`timescale 1ns/1ps
module hybrid_phase_pwm #(
  parameter int DUTY_W      = hpwm_pkg::DUTY_W,
  parameter int FINE_W      = hpwm_pkg::FINE_W,
  parameter int SYNC_STAGES = hpwm_pkg::SYNC_STAGES
) (
  input  logic              clk_p0,
  input  logic              clk_p90,
  input  logic              clk_p180,
  input  logic              clk_p270,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              duty_load,
  output logic              pwm_out
);
  localparam int NPHASE = 1 << FINE_W;

  logic [NPHASE-1:0] ph_clk;
  logic [NPHASE-1:0] ph_rst_n;
  logic [NPHASE-1:0] taps;
  logic              coarse_pulse;
  logic [FINE_W-1:0] fine_sel;
  logic              wrap;
  logic              idle;

  assign ph_clk = {clk_p270, clk_p180, clk_p90, clk_p0};

  genvar g;
  generate
    for (g = 0; g < NPHASE; g++) begin : g_rst
      hpwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rs (
        .clk_i  (ph_clk[g]),
        .arst_ni(rst_n),
        .rst_no (ph_rst_n[g])
      );
    end
  endgenerate

  hpwm_coarse #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_coarse (
    .clk_i  (ph_clk[0]),
    .rst_ni (ph_rst_n[0]),
    .duty_i (duty_in),
    .load_i (duty_load),
    .pulse_o(coarse_pulse),
    .fine_o (fine_sel),
    .wrap_o (wrap),
    .idle_o (idle)
  );

  assign taps[0] = coarse_pulse;

  generate
    for (g = 1; g < NPHASE; g++) begin : g_tap
      hpwm_phase_tap u_tap (
        .clk_i (ph_clk[g]),
        .rst_ni(ph_rst_n[g]),
        .d_i   (coarse_pulse),
        .q_o   (taps[g])
      );
    end
  endgenerate

  hpwm_merge #(.SEL_W(FINE_W), .NSEL(NPHASE)) u_merge (
    .set_i(coarse_pulse),
    .tap_i(taps),
    .sel_i(fine_sel),
    .pwm_o(pwm_out)
  );

  // A zero whole-clock count keeps the output low once settled (R4)
  p_idle_low_r4: assert property (@(posedge clk_p0) disable iff (!ph_rst_n[0])
    (idle && !wrap) |=> !pwm_out);
  // Output is never high while the coarse stage is idle and no tap is up (R3)
  p_taps_low_r3: assert property (@(posedge clk_p0) disable iff (!ph_rst_n[0])
    (taps == '0) |-> !pwm_out);
endmodule

// File: tb/sim_hybrid_phase_pwm.sv
`timescale 1ns/1ps
module sim_hybrid_phase_pwm;
  logic       clk0 = 1'b0;
  logic       clk90 = 1'b0;
  logic       clk180, clk270;
  logic       rst_n;
  logic [8:0] duty_in;
  logic       duty_load;
  logic       pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // 250 MHz, quarter-period phase offsets of 1 ns
  always #2 clk0 = ~clk0;
  initial begin
    #1;
    forever #2 clk90 = ~clk90;
  end
  assign clk180 = ~clk0;
  assign clk270 = ~clk90;

  hybrid_phase_pwm u0 (
    .clk_p0   (clk0),
    .clk_p90  (clk90),
    .clk_p180 (clk180),
    .clk_p270 (clk270),
    .rst_n    (rst_n),
    .duty_in  (duty_in),
    .duty_load(duty_load),
    .pwm_out  (pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ns(input int code);
    int c = code >> 2;
    int f = code & 3;
    return (c == 0) ? 0 : 4 * c + f;
  endfunction

  // High samples over one full period (2048 samples of 0.25 ns)
  task automatic measure(output int hi);
    hi = 0;
    @(posedge clk0);
    #0.125;
    for (int i = 0; i < 2048; i++) begin
      if (pwm_out) hi++;
      #0.25;
    end
  endtask

  task automatic load(input int d);
    @(negedge clk0);
    duty_in   = 9'(d);
    duty_load = 1'b1;
    @(negedge clk0);
    duty_load = 1'b0;
  endtask

  task automatic apply_and_check(input string req, input int d);
    int hi;
    load(d);
    #1100;
    measure(hi);
    chk($sformatf("%s code %0d high quarter-ns", req, d), hi, 4 * exp_ns(d));
  endtask

  task automatic t_reset_state;
    int hi;
    rst_n = 1'b0; duty_in = '0; duty_load = 1'b0;
    #21;
    chk("R9 output low in reset", int'(pwm_out), 0);
    @(negedge clk0); rst_n = 1'b1;
    #600;
    measure(hi);
    chk("R9 output low after release", hi, 0);
  endtask

  task automatic t_coarse_only;
    apply_and_check("R2", 4);
    apply_and_check("R2", 8);
    apply_and_check("R2", 200);
    apply_and_check("R2", 400);
  endtask

  task automatic t_fine_steps;
    apply_and_check("R3", 5);
    apply_and_check("R3", 6);
    apply_and_check("R3", 7);
    apply_and_check("R3", 201);
    apply_and_check("R3", 202);
    apply_and_check("R3", 203);
  endtask

  task automatic t_dead_zone;
    apply_and_check("R4", 3);
    apply_and_check("R4", 1);
    apply_and_check("R4", 2);
    apply_and_check("R4", 0);
  endtask

  task automatic t_full_scale;
    apply_and_check("R5", 511);
    apply_and_check("R5", 510);
  endtask

  task automatic t_period;
    realtime r0, r1;
    load(300);
    #1100;
    @(posedge pwm_out); r0 = $realtime;
    @(posedge pwm_out); r1 = $realtime;
    chk("R1 pulse spacing ns", int'(r1 - r0), 512);
  endtask

  task automatic t_defer;
    realtime tr, tf;
    load(200);
    #1100;
    @(posedge pwm_out); tr = $realtime;
    repeat (10) @(posedge clk0);
    load(64);
    @(negedge pwm_out); tf = $realtime;
    chk("R6 current pulse keeps old width", int'(tf - tr), 200);
    @(posedge pwm_out); tr = $realtime;
    @(negedge pwm_out); tf = $realtime;
    chk("R6 next pulse uses new word", int'(tf - tr), 64);
  endtask

  task automatic t_bypass;
    realtime r0, r1, tf;
    load(160);
    #1100;
    @(posedge pwm_out); r0 = $realtime;
    repeat (127) @(posedge clk0);
    @(negedge clk0);
    duty_in = 9'd91; duty_load = 1'b1;
    @(posedge pwm_out); r1 = $realtime;
    @(negedge clk0); duty_load = 1'b0;
    @(negedge pwm_out); tf = $realtime;
    chk("R7 new period starts on time", int'(r1 - r0), 512);
    chk("R7 load on wrap applies at once", int'(tf - r1), 91);
  endtask

  task automatic t_last_load;
    realtime tr, tf;
    load(100);
    #1100;
    @(posedge pwm_out);
    repeat (5) @(posedge clk0);
    load(300);
    repeat (7) @(posedge clk0);
    load(121);
    @(posedge pwm_out); tr = $realtime;
    @(negedge pwm_out); tf = $realtime;
    chk("R8 last loaded word wins", int'(tf - tr), 121);
  endtask

  task automatic t_reset_mid;
    int hi;
    load(400);
    #1100;
    @(posedge pwm_out);
    #5;
    rst_n = 1'b0;
    #0.5;
    chk("R9 async clear forces low", int'(pwm_out), 0);
    #20;
    @(negedge clk0); rst_n = 1'b1;
    #600;
    measure(hi);
    chk("R9 duty cleared by reset", hi, 0);
    apply_and_check("R9 recovery", 402);
  endtask

  initial begin
    t_reset_state();
    t_coarse_only();
    t_fine_steps();
    t_full_scale();
    t_dead_zone();
    t_period();
    t_defer();
    t_bypass();
    t_last_load();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule